// File: doc/BRIEF.md
# Paged EEPROM Transfer Sequencer

This block takes one read or write request aimed at a serial two-wire EEPROM and breaks it into a series of bus transactions. It hands them, one byte command at a time, to a downstream byte-level bus master. A request carries a 19-bit byte address, a 16-bit byte count, a direction and two optional length limits, one for reads and one for writes. Each transaction opens with a START and a device-select byte. That byte is built from the fixed prefix 1010, the top three address bits and a direction bit. Two memory-offset bytes follow, then the data, and the last data byte closes the transaction with STOP. A read puts a repeated START and a read-direction device byte between the offset and the data.

Writes are split so that no transaction crosses a 256-byte page. After each write transaction the block waits a fixed self-timed write cycle of 10 ms, counted in clock cycles from a clock-frequency parameter. A nonzero length limit counts the two offset bytes, so it first cuts the request into segments of at most limit minus two data bytes, and the page rule then splits writes within each segment. Write data is pulled from an upstream valid/ready byte stream. Read data is passed on as a one-cycle valid strobe. The block finishes with a single-cycle done pulse that carries a status and a byte count.

Top module: `eeprom_xfer_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is accepted on `req_valid && req_ready`, and `req_ready` stays low from the cycle after acceptance until the done pulse has ended.
- R2: Each transaction begins with a START command carrying the byte {1010, A18, A17, A16, 0}. A read transaction then sends a second START command carrying {1010, A18, A17, A16, 1} after the offset bytes.
- R3: Right after the first device byte come two plain byte commands, A15:A8 first and then A7:A0, in both directions.
- R4: A write transaction carries min(256 − A[7:0], bytes left in the current segment) data bytes, so it never crosses a 256-byte page.
- R5: A read transaction carries all bytes left in the current segment, whatever the page position.
- R6: The limit is `req_rd_limit` for reads and `req_wr_limit` for writes. 0 means no limit. A value L of 3 or more cuts the request, from its start, into segments of min(L − 2, bytes remaining), and writes are split further by R4 inside each segment.
- R7: A selected limit of 1 or 2 completes in the cycle after acceptance with status 1 (bad limit), count 0 and no bus command. This check applies even to a zero-length request.
- R8: Exactly the last data command of each transaction has `bm_stop` set. A command's flags are held while `bm_valid` waits for `bm_ready`.
- R9: After the response to the final byte of a write transaction, at least CLK_HZ/100 cycles pass before the next START command or the done pulse.
- R10: After each transaction the address advances by its length, modulo 2^19, and the carry into A18:A16 shows in later device bytes.
- R11: A response with `bm_rsp_fail` set ends the request. No further command is issued, and done follows in the next cycle with status 2 and a count of the bytes in transactions completed before the failure.
- R12: A successful request ends with a one-cycle done pulse with status 0 and a count equal to the requested length.
- R13: A zero-length request with an acceptable limit completes in the cycle after acceptance with status 0, count 0 and no bus command.
- R14: Write data bytes are taken from the upstream stream in order, one per data command. Each read data response is presented on `rd_data` with `rd_valid` in the cycle its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 19 | Starting EEPROM byte address |
| req_len | input | LEN_W | Byte count |
| req_rd_limit | input | LEN_W | Read length limit including offset bytes, 0 = none |
| req_wr_limit | input | LEN_W | Write length limit including offset bytes, 0 = none |
| wd_valid | input | 1 | Write data byte available |
| wd_ready | output | 1 | Write data byte taken |
| wd_data | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data byte strobe |
| rd_data | output | 8 | Read data byte |
| bm_valid | output | 1 | Byte command to bus master valid |
| bm_ready | input | 1 | Bus master accepts command |
| bm_byte | output | 8 | Byte to send (ignored for read slots) |
| bm_start | output | 1 | Issue START or repeated START before the byte |
| bm_stop | output | 1 | Issue STOP after the byte |
| bm_read | output | 1 | Read a byte instead of sending one |
| bm_rsp_valid | input | 1 | Command completion from bus master |
| bm_rsp_fail | input | 1 | Completion reports NACK or bus error |
| bm_rsp_data | input | 8 | Byte read by a read slot |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 bad limit, 2 bus failure |
| done_count | output | LEN_W | Bytes transferred |

## Verification
Each byte command is compared against a bench-built expected list as soon as `bm_valid` is seen, and read data is sampled just after the bench raises the matching response, because `rd_valid` follows that response in the same cycle. The bad-limit and zero-length results are due in the first cycle after acceptance and are sampled at the falling edge right after it, which is also where `req_ready` must already be low. The write-cycle gap is measured from the clock edge that takes the final-byte response. The next START appears CLK_HZ/100 + 1 cycles later and done appears CLK_HZ/100 cycles later, so the bench requires at least CLK_HZ/100 cycles. A failure response must be followed one cycle later by done, with no further command.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  localparam int ADDR_W   = 19;
  localparam int DEV_HI_W = 3;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_CMD, S_RSP, S_WCYC, S_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    PH_DEVW, PH_OFFH, PH_OFFL, PH_DEVR, PH_DATA
  } phase_e;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_BAD_LIMIT = 2'd1,
    ST_BUS_FAIL  = 2'd2
  } xfer_status_e;

  typedef struct packed {
    logic [7:0] data;
    logic       start;
    logic       stop;
    logic       rd;
  } bm_cmd_t;

endpackage

// File: rtl/eeprom_rst_sync.sv
module eeprom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/eeprom_chunk_plan.sv
module eeprom_chunk_plan #(
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic                 is_write,
  input  logic [PAGE_BITS-1:0] addr_lo,
  input  logic [LEN_W-1:0]     remaining,
  input  logic [LEN_W-1:0]     seg_left,
  input  logic                 cap_en,
  input  logic [LEN_W-1:0]     cap,
  output logic [LEN_W-1:0]     seg_len,
  output logic [LEN_W-1:0]     chunk_len
);
  localparam logic [LEN_W-1:0] PAGE_SIZE = LEN_W'(1) << PAGE_BITS;

  logic [LEN_W-1:0] seg_fresh;
  logic [LEN_W-1:0] page_room;

  always_comb begin
    // open a new segment only when the previous one is used up
    seg_fresh = (cap_en && (cap < remaining)) ? cap : remaining;
    seg_len   = (seg_left == '0) ? seg_fresh : seg_left;
    page_room = PAGE_SIZE - LEN_W'(addr_lo);
    chunk_len = (is_write && (page_room < seg_len)) ? page_room : seg_len;
  end
endmodule

// File: rtl/eeprom_cmd_build.sv
module eeprom_cmd_build
  import eeprom_seq_pkg::*;
(
  input  phase_e              phase,
  input  logic                is_read,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic                last_data,
  output bm_cmd_t             cmd
);
  logic [DEV_HI_W-1:0] dev_hi;
  assign dev_hi = addr[ADDR_W-1 -: DEV_HI_W];

  always_comb begin
    cmd = '0;
    unique case (phase)
      PH_DEVW: begin
        cmd.data  = {DEV_PREFIX, dev_hi, 1'b0};
        cmd.start = 1'b1;
      end
      PH_OFFH: cmd.data = addr[15:8];
      PH_OFFL: cmd.data = addr[7:0];
      PH_DEVR: begin
        cmd.data  = {DEV_PREFIX, dev_hi, 1'b1};
        cmd.start = 1'b1;
      end
      PH_DATA: begin
        cmd.data = is_read ? 8'h00 : wdata;
        cmd.rd   = is_read;
        cmd.stop = last_data;
      end
      default: cmd = '0;
    endcase
  end
endmodule

// File: rtl/eeprom_wcycle_timer.sv
module eeprom_wcycle_timer #(
  parameter int WAIT_CYC = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? LOAD : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign fire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/eeprom_xfer_seq.sv
module eeprom_xfer_seq
  import eeprom_seq_pkg::*;
#(
  parameter int CLK_HZ    = 250_000_000,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [18:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [LEN_W-1:0]  req_rd_limit,
  input  logic [LEN_W-1:0]  req_wr_limit,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [7:0]        wd_data,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              bm_valid,
  input  logic              bm_ready,
  output logic [7:0]        bm_byte,
  output logic              bm_start,
  output logic              bm_stop,
  output logic              bm_read,
  input  logic              bm_rsp_valid,
  input  logic              bm_rsp_fail,
  input  logic [7:0]        bm_rsp_data,
  output logic              done,
  output logic [1:0]        done_status,
  output logic [LEN_W-1:0]  done_count
);
  localparam int WAIT_RAW = CLK_HZ / 100;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam logic [LEN_W-1:0] OFFSET_BYTES = LEN_W'(2);

  logic rst_sync_n;

  seq_state_e        state_q, state_d;
  phase_e            phase_q, phase_d;
  xfer_status_e      status_q, status_d;
  logic              rd_dir_q, rd_dir_d;
  logic              cap_en_q, cap_en_d;
  logic [LEN_W-1:0]  cap_q, cap_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  seg_q, seg_d;
  logic [LEN_W-1:0]  chunk_q, chunk_d;
  logic [LEN_W-1:0]  dcnt_q, dcnt_d;
  logic [LEN_W-1:0]  moved_q, moved_d;

  logic [LEN_W-1:0]  sel_limit;
  logic              bad_limit, accept, in_data_wr, last_data;
  logic              rsp_ok, chunk_end, wc_start, wc_fire;
  logic [LEN_W-1:0]  plan_seg, plan_chunk;
  bm_cmd_t           cmd;

  eeprom_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eeprom_chunk_plan #(.LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) u_plan (
    .is_write  (!rd_dir_q),
    .addr_lo   (addr_q[PAGE_BITS-1:0]),
    .remaining (rem_q),
    .seg_left  (seg_q),
    .cap_en    (cap_en_q),
    .cap       (cap_q),
    .seg_len   (plan_seg),
    .chunk_len (plan_chunk)
  );

  eeprom_cmd_build u_cmd (
    .phase     (phase_q),
    .is_read   (rd_dir_q),
    .addr      (addr_q),
    .wdata     (wd_data),
    .last_data (last_data),
    .cmd       (cmd)
  );

  eeprom_wcycle_timer #(.WAIT_CYC(WAIT_CYC)) u_wcyc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (wc_start),
    .fire  (wc_fire)
  );

  // ---------------- combinational interface ----------------
  always_comb begin
    sel_limit  = req_read ? req_rd_limit : req_wr_limit;
    bad_limit  = (sel_limit != '0) && (sel_limit <= OFFSET_BYTES);
    req_ready  = (state_q == S_IDLE);
    accept     = req_valid && req_ready;
    in_data_wr = (phase_q == PH_DATA) && !rd_dir_q;
    last_data  = (dcnt_q == LEN_W'(1));

    bm_valid   = (state_q == S_CMD) && (!in_data_wr || wd_valid);
    wd_ready   = (state_q == S_CMD) && in_data_wr && bm_ready;
    bm_byte    = cmd.data;
    bm_start   = cmd.start;
    bm_stop    = cmd.stop;
    bm_read    = cmd.rd;

    rsp_ok     = (state_q == S_RSP) && bm_rsp_valid && !bm_rsp_fail;
    chunk_end  = rsp_ok && (phase_q == PH_DATA) && last_data;
    wc_start   = chunk_end && !rd_dir_q;
    rd_valid   = rsp_ok && (phase_q == PH_DATA) && rd_dir_q;
    rd_data    = bm_rsp_data;

    done        = (state_q == S_DONE);
    done_status = status_q;
    done_count  = moved_q;
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    status_d = status_q;
    rd_dir_d = rd_dir_q;
    cap_en_d = cap_en_q;
    cap_d    = cap_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    seg_d    = seg_q;
    chunk_d  = chunk_q;
    dcnt_d   = dcnt_q;
    moved_d  = moved_q;

    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          rd_dir_d = req_read;
          addr_d   = req_addr;
          rem_d    = req_len;
          seg_d    = '0;
          moved_d  = '0;
          cap_en_d = (sel_limit != '0);
          cap_d    = sel_limit - OFFSET_BYTES;
          status_d = ST_OK;
          if (bad_limit) begin
            status_d = ST_BAD_LIMIT;
            state_d  = S_DONE;
          end else if (req_len == '0) begin
            state_d  = S_DONE;
          end else begin
            state_d  = S_PLAN;
          end
        end
      end
      S_PLAN: begin
        seg_d   = plan_seg;
        chunk_d = plan_chunk;
        dcnt_d  = plan_chunk;
        phase_d = PH_DEVW;
        state_d = S_CMD;
      end
      S_CMD: begin
        if (bm_valid && bm_ready) state_d = S_RSP;
      end
      S_RSP: begin
        if (bm_rsp_valid) begin
          if (bm_rsp_fail) begin
            status_d = ST_BUS_FAIL;
            state_d  = S_DONE;
          end else begin
            state_d = S_CMD;
            unique case (phase_q)
              PH_DEVW: phase_d = PH_OFFH;
              PH_OFFH: phase_d = PH_OFFL;
              PH_OFFL: phase_d = rd_dir_q ? PH_DEVR : PH_DATA;
              PH_DEVR: phase_d = PH_DATA;
              default: begin
                if (last_data) begin
                  addr_d  = addr_q + ADDR_W'(chunk_q);
                  rem_d   = rem_q - chunk_q;
                  seg_d   = seg_q - chunk_q;
                  moved_d = moved_q + chunk_q;
                  if (!rd_dir_q)            state_d = S_WCYC;
                  else if (rem_q == chunk_q) state_d = S_DONE;
                  else                      state_d = S_PLAN;
                end else begin
                  dcnt_d = dcnt_q - LEN_W'(1);
                end
              end
            endcase
          end
        end
      end
      S_WCYC: begin
        if (wc_fire) state_d = (rem_q == '0) ? S_DONE : S_PLAN;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= S_IDLE;
      phase_q  <= PH_DEVW;
      status_q <= ST_OK;
      rd_dir_q <= 1'b0;
      cap_en_q <= 1'b0;
      cap_q    <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      seg_q    <= '0;
      chunk_q  <= '0;
      dcnt_q   <= '0;
      moved_q  <= '0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      status_q <= status_d;
      rd_dir_q <= rd_dir_d;
      cap_en_q <= cap_en_d;
      cap_q    <= cap_d;
      addr_q   <= addr_d;
      rem_q    <= rem_d;
      seg_q    <= seg_d;
      chunk_q  <= chunk_d;
      dcnt_q   <= dcnt_d;
      moved_q  <= moved_d;
    end
  end
endmodule

// File: rtl/eeprom_xfer_seq_chk.sv
module eeprom_xfer_seq_chk #(
  parameter int LEN_W    = 16,
  parameter int WAIT_CYC = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_read,
  input logic [LEN_W-1:0] req_len,
  input logic [LEN_W-1:0] req_rd_limit,
  input logic [LEN_W-1:0] req_wr_limit,
  input logic             bm_valid,
  input logic             bm_ready,
  input logic [3:0]       bm_prefix,
  input logic             bm_start,
  input logic             bm_stop,
  input logic             bm_read,
  input logic             bm_rsp_valid,
  input logic             bm_rsp_fail,
  input logic             done,
  input logic [1:0]       done_status,
  input logic [LEN_W-1:0] done_count
);
  logic             acc;
  logic [LEN_W-1:0] lim;
  logic             wr_stop_hs_q, armed_q;
  logic [31:0]      gap_q;

  assign acc = req_valid && req_ready;
  assign lim = req_read ? req_rd_limit : req_wr_limit;

  // write-cycle gap tracker: counts cycles since a write STOP byte completed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stop_hs_q <= 1'b0;
      armed_q      <= 1'b0;
      gap_q        <= '0;
    end else begin
      if (bm_valid && bm_ready) wr_stop_hs_q <= bm_stop && !bm_read;
      if (bm_rsp_valid && !bm_rsp_fail && wr_stop_hs_q) begin
        armed_q <= 1'b1;
        gap_q   <= '0;
      end else if (armed_q && (done || (bm_valid && bm_start))) begin
        armed_q <= 1'b0;
      end else if (armed_q) begin
        gap_q <= gap_q + 32'd1;
      end
    end
  end

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  p_dev_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_valid && bm_start) |-> (bm_prefix == 4'b1010));

  p_bad_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (lim != '0) && (lim <= LEN_W'(2))) |=> (done && done_status == 2'd1));

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_valid && !bm_ready) |=> (bm_valid && $stable({bm_start, bm_stop, bm_read})));

  p_wr_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (done || (bm_valid && bm_start))) |-> (gap_q >= 32'(WAIT_CYC)));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_rsp_valid && bm_rsp_fail) |=> (done && !bm_valid && done_status == 2'd2));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_zero_len_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_len == '0 && !((lim != '0) && (lim <= LEN_W'(2))))
      |=> (done && done_status == 2'd0 && done_count == '0));
endmodule

bind eeprom_xfer_seq eeprom_xfer_seq_chk #(.LEN_W(LEN_W), .WAIT_CYC(WAIT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_read     (req_read),
  .req_len      (req_len),
  .req_rd_limit (req_rd_limit),
  .req_wr_limit (req_wr_limit),
  .bm_valid     (bm_valid),
  .bm_ready     (bm_ready),
  .bm_prefix    (bm_byte[7:4]),
  .bm_start     (bm_start),
  .bm_stop      (bm_stop),
  .bm_read      (bm_read),
  .bm_rsp_valid (bm_rsp_valid),
  .bm_rsp_fail  (bm_rsp_fail),
  .done         (done),
  .done_status  (done_status),
  .done_count   (done_count)
);

// File: tb/eeprom_xfer_seq_test.sv
`timescale 1ns/1ps
module eeprom_xfer_seq_test;
  localparam int CLK_HZ = 2500;
  localparam int WAITC  = CLK_HZ / 100;
  localparam int NE     = 2048;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_read;
  logic [18:0] req_addr;
  logic [15:0] req_len, req_rd_limit, req_wr_limit;
  logic        wd_valid, wd_ready;
  logic [7:0]  wd_data;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        bm_valid, bm_ready, bm_start, bm_stop, bm_read;
  logic [7:0]  bm_byte;
  logic        bm_rsp_valid, bm_rsp_fail;
  logic [7:0]  bm_rsp_data;
  logic        done;
  logic [1:0]  done_status;
  logic [15:0] done_count;

  eeprom_xfer_seq #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_addr(req_addr), .req_len(req_len),
    .req_rd_limit(req_rd_limit), .req_wr_limit(req_wr_limit),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .bm_valid(bm_valid), .bm_ready(bm_ready), .bm_byte(bm_byte),
    .bm_start(bm_start), .bm_stop(bm_stop), .bm_read(bm_read),
    .bm_rsp_valid(bm_rsp_valid), .bm_rsp_fail(bm_rsp_fail), .bm_rsp_data(bm_rsp_data),
    .done(done), .done_status(done_status), .done_count(done_count)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit rst_done = 0;

  // expected command list
  logic [7:0]  e_byte [NE];
  logic        e_start[NE], e_stop[NE], e_rd[NE];
  logic [18:0] e_addr [NE];
  int          e_chunk[NE];
  int          n_exp, eidx, fail_at, exp_status;
  logic [7:0]  wsrc [1024];
  int          wptr;
  bit          wc_pend;
  int          wc_cyc;

  initial clk = 0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign wd_data = wsrc[wptr[9:0]];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'h0B};
  endfunction

  task automatic push(input logic [7:0] b, input bit s, input bit p, input bit r,
                      input logic [18:0] a, input int ch);
    e_byte[n_exp] = b; e_start[n_exp] = s; e_stop[n_exp] = p; e_rd[n_exp] = r;
    e_addr[n_exp] = a; e_chunk[n_exp] = ch;
    n_exp++;
  endtask

  // builds the expected commands from the requirements (R2..R6, R10)
  task automatic build(input bit rd, input logic [18:0] a0, input int len, input int lim);
    int rem, cap, seg, c, wi;
    logic [18:0] a;
    n_exp = 0;
    exp_status = 0;
    if (lim != 0 && lim <= 2) begin exp_status = 1; return; end
    rem = len; a = a0; wi = 0;
    cap = (lim == 0) ? 65535 : lim - 2;
    while (rem > 0) begin
      seg = (cap < rem) ? cap : rem;
      while (seg > 0) begin
        c = rd ? seg : ((256 - int'(a[7:0])) < seg ? (256 - int'(a[7:0])) : seg);
        push({4'b1010, a[18:16], 1'b0}, 1, 0, 0, a, 0);
        push(a[15:8], 0, 0, 0, a, 0);
        push(a[7:0], 0, 0, 0, a, 0);
        if (rd) push({4'b1010, a[18:16], 1'b1}, 1, 0, 0, a, 0);
        for (int i = 0; i < c; i++) begin
          push(rd ? 8'h00 : wsrc[wi], 0, i == c - 1, rd, a + 19'(i), (i == c - 1) ? c : 0);
          if (!rd) wi++;
        end
        a = a + 19'(c);
        seg -= c;
        rem -= c;
      end
    end
  endtask

  // bus master responder
  initial begin
    bm_ready = 0; bm_rsp_valid = 0; bm_rsp_fail = 0; bm_rsp_data = 0;
    forever begin
      @(negedge clk);
      if (rst_done && bm_valid) begin
        int my;
        bit fl, rs, cons;
        my = eidx;
        eidx++;
        if (wc_pend) begin
          check((cyc - wc_cyc) >= WAITC, "R9 write cycle gap before START", cyc - wc_cyc, WAITC);
          wc_pend = 0;
        end
        if (my >= n_exp) begin
          check(0, "R11 unexpected extra command", my, n_exp);
          my = NE - 1;
          rs = 0;
        end else begin
          rs = e_rd[my];
          check(bm_start == e_start[my], "R2 start flag", bm_start, e_start[my]);
          check(bm_stop == e_stop[my], "R8 stop flag", bm_stop, e_stop[my]);
          check(bm_read == e_rd[my], "R5 read slot flag", bm_read, e_rd[my]);
          if (!e_rd[my])
            check(bm_byte == e_byte[my], "R3/R4/R10/R14 command byte", bm_byte, e_byte[my]);
        end
        bm_ready = 1;
        #1 cons = wd_ready;
        @(negedge clk);
        bm_ready = 0;
        if (cons) wptr++;
        repeat ($urandom % 3) @(negedge clk);
        fl = (my == fail_at);
        bm_rsp_valid = 1;
        bm_rsp_fail  = fl;
        bm_rsp_data  = rs ? pat(e_addr[my]) : 8'h5A;
        #1;
        if (rs && !fl) begin
          check(rd_valid == 1'b1, "R14 rd_valid with read response", rd_valid, 1);
          check(rd_data == pat(e_addr[my]), "R14 read data", rd_data, pat(e_addr[my]));
        end else begin
          check(rd_valid == 1'b0, "R14 no rd_valid", rd_valid, 0);
        end
        if (!fl && !rs && e_chunk[my] != 0) begin
          wc_pend = 1;
          wc_cyc  = cyc + 1;
        end
        @(negedge clk);
        bm_rsp_valid = 0;
        bm_rsp_fail  = 0;
      end
    end
  end

  task automatic run(input bit rd, input logic [18:0] a, input int len,
                     input int rlim, input int wlim, input int fidx, input string nm);
    int lim, exp_cnt, exp_used, exp_st;
    lim = rd ? rlim : wlim;
    for (int i = 0; i < 1024; i++) wsrc[i] = 8'($urandom);
    wptr = 0; eidx = 0; wc_pend = 0;
    build(rd, a, len, lim);
    fail_at = (fidx >= 0 && fidx < n_exp) ? fidx : -1;
    exp_cnt = len; exp_used = n_exp; exp_st = exp_status;
    if (exp_st == 1) exp_cnt = 0;
    if (fail_at >= 0) begin
      exp_cnt = 0;
      for (int j = 0; j < fail_at; j++) exp_cnt += e_chunk[j];
      exp_used = fail_at + 1;
      exp_st = 2;
    end
    @(negedge clk);
    req_valid = 1; req_read = rd; req_addr = a; req_len = 16'(len);
    req_rd_limit = 16'(rlim); req_wr_limit = 16'(wlim);
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 1'b0, {"R1 busy after accept ", nm}, req_ready, 0);
    if (exp_st == 1)
      check(done == 1'b1, {"R7 immediate done ", nm}, done, 1);
    else if (len == 0)
      check(done == 1'b1, {"R13 immediate done ", nm}, done, 1);
    while (!done) @(negedge clk);
    if (wc_pend) begin
      check((cyc - wc_cyc) >= WAITC, {"R9 write cycle gap before done ", nm}, cyc - wc_cyc, WAITC);
      wc_pend = 0;
    end
    check(done_status == 2'(exp_st), {"R7/R11/R12 status ", nm}, done_status, exp_st);
    check(done_count == 16'(exp_cnt), {"R11/R12/R13 count ", nm}, done_count, exp_cnt);
    check(eidx == exp_used, {"R6/R11 command total ", nm}, eidx, exp_used);
    @(negedge clk);
    check(done == 1'b0, {"R12 done one cycle ", nm}, done, 0);
    check(req_ready == 1'b1, {"R1 ready after done ", nm}, req_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; req_valid = 0; req_read = 0; req_addr = 0; req_len = 0;
    req_rd_limit = 0; req_wr_limit = 0; wd_valid = 1;
    n_exp = 0; eidx = 0; fail_at = -1; wptr = 0; wc_pend = 0; wc_cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rst_done = 1;
    check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    check(bm_valid == 1'b0, "R1 reset no command", bm_valid, 0);
    check(done == 1'b0, "R12 reset no done", done, 0);

    run(0, 19'h000F0, 40, 0, 0, -1, "R4 page split write");
    run(1, 19'h6DA01, 300, 0, 0, -1, "R5 long read one transaction");
    run(0, 19'h000F0, 200, 0, 102, -1, "R6 write limit nested");
    run(1, 19'h01234, 120, 50, 3, -1, "R6 read limit");
    run(0, 19'h00010, 10, 0, 2, -1, "R7 bad write limit");
    run(1, 19'h00010, 0, 1, 0, -1, "R7 bad limit zero length");
    run(0, 19'h00020, 0, 0, 0, -1, "R13 zero length");
    run(0, 19'h0FFF8, 20, 0, 0, -1, "R10 carry into device bits");
    run(1, 19'h7FFFE, 5, 0, 0, -1, "R10 wrap read");
    run(0, 19'h000F0, 40, 0, 0, 25, "R11 fail in second chunk");
    run(1, 19'h00100, 8, 0, 0, 1, "R11 fail on offset");
    run(0, 19'h00001, 4, 0, 3, -1, "R6 one byte per transaction");

    for (int k = 0; k < 20; k++) begin
      bit rd;
      int len, rl, wl, fi;
      rd = 1'($urandom);
      len = ($urandom % 8 == 0) ? 0 : int'($urandom % 300) + 1;
      rl = ($urandom % 3 == 0) ? 0 : int'($urandom % 200) + 8;
      wl = ($urandom % 3 == 0) ? 0 : int'($urandom % 200) + 8;
      fi = ($urandom % 4 == 0) ? int'($urandom % 200) : -1;
      run(rd, 19'($urandom), len, rl, wl, fi, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule